// File: doc/BRIEF.md
# Address-Window Region Decoder with Width and Alignment Validation

This block sits behind a bus slave port and in front of a bank of register windows. Each incoming access carries an absolute address, a size code, a direction and write data. The decoder subtracts a fixed device base address and compares the resulting offset against every window in parallel. It then checks the access size and natural alignment against the widths that window permits. The windows are described by a parameter table, where each entry gives a start offset, a length, a set of permitted widths and a handler kind.

A legal access to an externally handled window is passed on to the downstream register bank one cycle later. That forwarded access carries a one-hot window select, a strobe, the byte offset inside the window, the direction and size-masked write data. Read data from the bank is returned in the same cycle as the strobe. The block also provides two built-in stub handlers: one window kind reads as zero and one reads as all ones, and writes to either stub are ignored.

An access that hits no window, or that breaks the width rules, raises no error. A write of this kind is dropped. A read of this kind completes with all-zero data, using the same one-cycle latency as a legal read.

Top module: `mmio_region_decoder`

## Requirements
- R1: The offset is the request address minus BASE_ADDR, taken modulo 2^AW. A window is hit when start <= offset < start + length. For a legal hit, sel_onehot has exactly the bit of that window set one cycle after the request, and is zero otherwise.
- R2: Size code 0 (1 byte) is legal only if bit 0 (8-bit allowed) is set in the window's flags.
- R3: Size code 2 (4 bytes) is legal only if bit 1 (32-bit allowed) is set in the window's flags and address bits [1:0] are zero.
- R4: Size code 3 (8 bytes) is legal only if bit 2 (64-bit allowed) is set in the window's flags and address bits [2:0] are zero. Size code 1 (2 bytes) is never legal.
- R5: A write that misses every window or is illegal produces no fwd_valid, and sel_onehot stays zero.
- R6: Every read produces rsp_valid exactly one cycle after the request. If the read misses or is illegal, rsp_rdata is zero.
- R7: Data is little-endian and right-justified. Byte k of a register travels on bits [8k+7:8k]. Bytes above the access size are zero in both rsp_rdata and fwd_wdata.
- R8: A legal read of a window of kind 1 (read-as-ones) returns all ones across the access width. A legal read of a window of kind 0 (read-as-zero) returns zero. Neither kind asserts fwd_valid.
- R9: A write to a kind 0 or kind 1 window is ignored: fwd_valid stays low, although sel_onehot still marks the window.
- R10: A legal access to a window of kind 2 (external) raises fwd_valid one cycle after the request. The same cycle carries fwd_write, fwd_size, fwd_offset = offset - start, and rsp_rdata = bank_rdata masked to the access size.
- R11: While rst_n is low at a clock edge, rsp_valid, fwd_valid and sel_onehot are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Absolute byte address |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_wdata | input | 64 | Write data, right-justified little-endian |
| rsp_valid | output | 1 | Read completion, one cycle after the request |
| rsp_rdata | output | 64 | Read data, masked to the access size |
| sel_onehot | output | NREG | Window select for a legal hit |
| fwd_valid | output | 1 | Validated access to an external window |
| fwd_write | output | 1 | Direction of the forwarded access |
| fwd_size | output | 2 | Size code of the forwarded access |
| fwd_offset | output | OFF_W | Byte offset within the selected window |
| fwd_wdata | output | 64 | Size-masked write data |
| bank_rdata | input | 64 | Register bank read value, sampled while fwd_valid is high |

## Verification
Assertions check several properties on every cycle:
- the select is never more than one-hot;
- a forwarded strobe always carries a select;
- a read always completes exactly one cycle later;
- narrow reads never leak upper bytes;
- a 2-byte access is never forwarded.

Other behaviour depends on the default window table, so only the bench scenarios can show it:
- the exact window boundaries (last byte in, first byte out);
- the per-window width flags;
- misalignment rejection;
- read-as-ones versus read-as-zero data;
- stub writes being dropped;
- offsets computed within each window.

// File: rtl/mrd_pkg.sv
// Shared types for the region decoder.
// Assumes size codes 0/1/2/3 mean 1/2/4/8 bytes.
package mrd_pkg;
    typedef enum logic [1:0] {
        KIND_RAZ = 2'd0,
        KIND_RAO = 2'd1,
        KIND_EXT = 2'd2
    } region_kind_e;

    localparam int FLAG_W8  = 0;
    localparam int FLAG_W32 = 1;
    localparam int FLAG_W64 = 2;

    localparam logic [1:0] SZ_1B = 2'd0;
    localparam logic [1:0] SZ_2B = 2'd1;
    localparam logic [1:0] SZ_4B = 2'd2;
    localparam logic [1:0] SZ_8B = 2'd3;
endpackage

// File: rtl/mrd_region_match.sv
// Range compare and width check for one window.
// Assumes START + LEN does not exceed 2^AW.
module mrd_region_match #(
    parameter int          AW    = 32,
    parameter logic [AW-1:0] START = '0,
    parameter logic [AW-1:0] LEN   = 'd4,
    parameter logic [2:0]  FLAGS = 3'b010
) (
    input  logic [AW-1:0] offset,
    input  logic [2:0]    addr_lo,
    input  logic [1:0]    size,
    output logic          hit,
    output logic          legal
);
    import mrd_pkg::*;

    localparam logic [AW:0] END_EXCL = {1'b0, START} + {1'b0, LEN};

    // Half-open range compare on the device offset.
    always_comb begin
        hit = (offset >= START) && ({1'b0, offset} < END_EXCL);
    end

    // Width and natural-alignment check against the window's flags.
    always_comb begin
        unique case (size)
            SZ_1B:   legal = FLAGS[FLAG_W8];
            SZ_4B:   legal = FLAGS[FLAG_W32] && (addr_lo[1:0] == 2'b00);
            SZ_8B:   legal = FLAGS[FLAG_W64] && (addr_lo == 3'b000);
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/mrd_pick.sv
// Lowest-index selector over a hit vector.
// Assumes windows do not overlap, so at most one bit is normally set.
module mrd_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set index wins.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mrd_lane_fmt.sv
// Masks a right-justified little-endian value to the access width.
// Byte k sits on bits [8k+7:8k]; bytes above the size are zeroed.
module mrd_lane_fmt #(
    parameter int DW = 64
) (
    input  logic [1:0]    size,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    logic [NB-1:0] byte_en;

    // Byte enable count from the size code: 1, 2, 4 or 8 bytes.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            byte_en[b] = (b < (1 << size));
        end
    end

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_lane
            assign dout[8*g +: 8] = byte_en[g] ? din[8*g +: 8] : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/mmio_region_decoder.sv
// Decodes bus accesses against a parameter table of windows.
// It validates the access width and alignment and forwards legal accesses
// to external windows one cycle later. Stub windows are served internally.
// Assumes windows are non-overlapping and sorted by start offset.
module mmio_region_decoder #(
    parameter int AW    = 32,
    parameter int NREG  = 4,
    parameter int OFF_W = 12,
    parameter logic [AW-1:0] BASE_ADDR = 32'h4000_0000,
    parameter logic [NREG-1:0][AW-1:0] REGION_START =
        {32'h0000_0200, 32'h0000_0100, 32'h0000_0008, 32'h0000_0000},
    parameter logic [NREG-1:0][AW-1:0] REGION_LEN =
        {32'h0000_0020, 32'h0000_0040, 32'h0000_0008, 32'h0000_0008},
    parameter logic [NREG-1:0][2:0] REGION_FLAGS =
        {3'b010, 3'b111, 3'b011, 3'b110},
    parameter logic [NREG-1:0][1:0] REGION_KIND =
        {2'd1, 2'd2, 2'd0, 2'd2}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_size,
    input  logic [63:0]      req_wdata,
    output logic             rsp_valid,
    output logic [63:0]      rsp_rdata,
    output logic [NREG-1:0]  sel_onehot,
    output logic             fwd_valid,
    output logic             fwd_write,
    output logic [1:0]       fwd_size,
    output logic [OFF_W-1:0] fwd_offset,
    output logic [63:0]      fwd_wdata,
    input  logic [63:0]      bank_rdata
);
    import mrd_pkg::*;

    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [AW-1:0]   dev_off;
    logic [NREG-1:0] hit_vec;
    logic [NREG-1:0] legal_vec;
    logic [NREG-1:0] hit_oh;
    logic [IW-1:0]   hit_idx;
    logic            acc_ok;
    logic [63:0]     wdata_masked;

    logic             s_valid;
    logic             s_write;
    logic             s_ok;
    logic [NREG-1:0]  s_sel;
    region_kind_e     s_kind;
    logic [1:0]       s_size;
    logic [OFF_W-1:0] s_off;
    logic [63:0]      s_wdata;
    logic [63:0]      rd_raw;
    logic [63:0]      rd_masked;

    // Device-relative offset, wrapping modulo 2^AW.
    assign dev_off = req_addr - BASE_ADDR;

    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_win
            mrd_region_match #(
                .AW   (AW),
                .START(REGION_START[r]),
                .LEN  (REGION_LEN[r]),
                .FLAGS(REGION_FLAGS[r])
            ) u_match (
                .offset (dev_off),
                .addr_lo(req_addr[2:0]),
                .size   (req_size),
                .hit    (hit_vec[r]),
                .legal  (legal_vec[r])
            );
        end
    endgenerate

    mrd_pick #(.N(NREG)) u_pick (
        .req  (hit_vec),
        .grant(hit_oh),
        .idx  (hit_idx)
    );

    // The access goes ahead only if the hit window also accepts its width.
    assign acc_ok = |(hit_oh & legal_vec);

    mrd_lane_fmt #(.DW(64)) u_wfmt (
        .size(req_size),
        .din (req_wdata),
        .dout(wdata_masked)
    );

    // Decode register stage: control fields with reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_ok    <= 1'b0;
            s_sel   <= '0;
        end else begin
            s_valid <= req_valid;
            s_ok    <= req_valid && acc_ok;
            s_sel   <= (req_valid && acc_ok) ? hit_oh : '0;
        end
    end

    // Decode register stage: payload fields, no reset needed.
    always_ff @(posedge clk) begin
        s_write <= req_write;
        s_kind  <= region_kind_e'(REGION_KIND[hit_idx]);
        s_size  <= req_size;
        s_off   <= OFF_W'(dev_off - REGION_START[hit_idx]);
        s_wdata <= wdata_masked;
    end

    // Read source: bank for external windows, stub constants otherwise.
    always_comb begin
        rd_raw = '0;
        if (s_ok) begin
            unique case (s_kind)
                KIND_EXT: rd_raw = bank_rdata;
                KIND_RAO: rd_raw = '1;
                default:  rd_raw = '0;
            endcase
        end
    end

    mrd_lane_fmt #(.DW(64)) u_rfmt (
        .size(s_size),
        .din (rd_raw),
        .dout(rd_masked)
    );

    assign rsp_valid  = s_valid && !s_write;
    assign rsp_rdata  = rsp_valid ? rd_masked : '0;
    assign sel_onehot = s_sel;
    assign fwd_valid  = s_ok && (s_kind == KIND_EXT);
    assign fwd_write  = s_write;
    assign fwd_size   = s_size;
    assign fwd_offset = s_off;
    assign fwd_wdata  = s_wdata;

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_onehot));

    // R10
    fwd_has_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (sel_onehot != '0));

    // R6
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R7
    narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == SZ_1B) |=> (rsp_rdata[63:8] == '0));

    // R4
    halfword_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == SZ_2B) |=> (!fwd_valid && sel_onehot == '0));
endmodule

// File: tb/mmio_region_decoder_test.sv
module mmio_region_decoder_test;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [3:0]  sel_onehot;
    logic        fwd_valid;
    logic        fwd_write;
    logic [1:0]  fwd_size;
    logic [11:0] fwd_offset;
    logic [63:0] fwd_wdata;
    logic [63:0] bank_rdata = 64'h1122_3344_5566_7788;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mmio_region_decoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sel_onehot(sel_onehot),
        .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_size(fwd_size),
        .fwd_offset(fwd_offset), .fwd_wdata(fwd_wdata), .bank_rdata(bank_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one access at a negedge; sample results one negedge later.
    task automatic access(input bit wr, input logic [31:0] off, input logic [1:0] sz,
                          input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = BASE + off;
        req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Read expecting a zero response with no select and no forward.
    task automatic read_rejected(input string req, input logic [31:0] off,
                                 input logic [1:0] sz);
        access(1'b0, off, sz, '0);
        check(req, "rsp_valid", 64'(rsp_valid), 64'd1);
        check(req, "rdata", rsp_rdata, 64'd0);
        check(req, "sel", 64'(sel_onehot), 64'd0);
        check(req, "fwd_valid", 64'(fwd_valid), 64'd0);
    endtask

    task automatic t_reset;
        check("R11", "rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11", "fwd_valid", 64'(fwd_valid), 64'd0);
        check("R11", "sel", 64'(sel_onehot), 64'd0);
    endtask

    task automatic t_ext_reads;
        access(1'b0, 32'h004, 2'd2, '0);        // R3 legal word, R10
        check("R10", "fwd_valid", 64'(fwd_valid), 64'd1);
        check("R10", "offset", 64'(fwd_offset), 64'h4);
        check("R7", "rdata word", rsp_rdata, 64'h0000_0000_5566_7788);
        check("R1", "sel", 64'(sel_onehot), 64'h1);
        access(1'b0, 32'h000, 2'd3, '0);        // R4 legal dword
        check("R4", "rdata dword", rsp_rdata, 64'h1122_3344_5566_7788);
        access(1'b0, 32'h13F, 2'd0, '0);        // R1 last byte of window 2, R2
        check("R1", "sel last byte", 64'(sel_onehot), 64'h4);
        check("R10", "offset last byte", 64'(fwd_offset), 64'h3F);
        check("R2", "rdata byte", rsp_rdata, 64'h88);
    endtask

    task automatic t_width_rules;
        read_rejected("R2", 32'h001, 2'd0);     // window 0 lacks 8-bit flag
        read_rejected("R4", 32'h104, 2'd3);     // misaligned dword
        read_rejected("R3", 32'h102, 2'd2);     // misaligned word
        read_rejected("R4", 32'h100, 2'd1);     // 2-byte never legal
        read_rejected("R6", 32'h140, 2'd2);     // first byte past window 2
        read_rejected("R6", 32'hFFFF_FFFC, 2'd2); // below base
    endtask

    task automatic t_stubs;
        access(1'b0, 32'h21C, 2'd2, '0);
        check("R8", "rao rdata", rsp_rdata, 64'h0000_0000_FFFF_FFFF);
        check("R8", "rao fwd", 64'(fwd_valid), 64'd0);
        check("R8", "rao sel", 64'(sel_onehot), 64'h8);
        read_rejected("R8", 32'h200, 2'd3);     // rao lacks 64-bit flag
        access(1'b0, 32'h00C, 2'd2, '0);
        check("R8", "raz rdata", rsp_rdata, 64'd0);
        check("R8", "raz sel", 64'(sel_onehot), 64'h2);
    endtask

    task automatic t_writes;
        access(1'b1, 32'h108, 2'd2, 64'hAABB_CCDD_EEFF_0011);
        check("R10", "wr fwd_valid", 64'(fwd_valid), 64'd1);
        check("R10", "wr fwd_write", 64'(fwd_write), 64'd1);
        check("R10", "wr offset", 64'(fwd_offset), 64'h8);
        check("R10", "wr size", 64'(fwd_size), 64'd2);
        check("R7", "wdata masked", fwd_wdata, 64'h0000_0000_EEFF_0011);
        check("R6", "no rsp on write", 64'(rsp_valid), 64'd0);
        access(1'b1, 32'h001, 2'd0, 64'h55);    // illegal width
        check("R5", "illegal wr fwd", 64'(fwd_valid), 64'd0);
        check("R5", "illegal wr sel", 64'(sel_onehot), 64'd0);
        access(1'b1, 32'h080, 2'd2, 64'h1);     // hole between windows
        check("R5", "miss wr fwd", 64'(fwd_valid), 64'd0);
        access(1'b1, 32'h008, 2'd2, 64'h1234);  // RAZ stub
        check("R9", "stub wr fwd", 64'(fwd_valid), 64'd0);
        check("R9", "stub wr sel", 64'(sel_onehot), 64'h2);
        access(1'b1, 32'h204, 2'd2, 64'h1234);  // RAO stub
        check("R9", "rao wr fwd", 64'(fwd_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ext_reads();
        t_width_rules();
        t_stubs();
        t_writes();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule